// File: doc/BRIEF.md
# Return-Address Stack with Banked Condition Flags

This block keeps the return addresses of a small Harvard-style controller whose program counter is 12 bits wide, so it spans 4096 program locations. Subroutine calls, maskable interrupt entry and non-maskable interrupt entry each push one entry onto a fixed-depth hardware LIFO. A subroutine return pops the address only. A return from interrupt pops the address and also the execution mode that was saved with it. The stack is a private structure and is never visible as data memory.

The block also holds the carry and zero flags. There is one copy of these flags for each of three execution modes: normal, interrupt and non-maskable interrupt. The mode register selects the active copy. ALU flag updates land only in that copy, and `c_o`/`z_o` always show it. So entering or leaving an interrupt changes the visible flags without saving them to memory.

Each cycle the controller presents its current instruction address, the target address or vector, and at most one strobe that takes effect. The block answers one cycle later with a registered redirect pulse and the new program counter.

Top module: `banked_call_stack`

## Requirements
- R1: After a synchronous reset the block is in this state:
  - the stack is empty (`depth_o`=0, `empty_o`=1, `full_o`=0);
  - the mode is normal (encoding 0);
  - all six flag bits are 0, so `c_o`=`z_o`=0;
  - `ovf_o`=`unf_o`=0;
  - `pc_o`=0 and `redir_o`=0.
- R2: A call pushes `pc_i`+2 (modulo 4096) with the current mode. In the next cycle `pc_o` equals `tgt_i` and `redir_o` is 1. The mode and the flags are unchanged.
- R3: A subroutine return on a non-empty stack pops the top entry. In the next cycle `pc_o` is the popped address and `redir_o` is 1. The mode and the flags are unchanged.
- R4: Interrupt entry does three things:
  - it pushes `pc_i` together with the current mode;
  - it loads `tgt_i` into `pc_o` and pulses `redir_o`;
  - it sets the mode to interrupt (encoding 1).
  While the mode is non-maskable (encoding 2), an interrupt strobe has no effect.
- R5: Non-maskable entry pushes `pc_i` with the current mode, loads `tgt_i` and sets the mode to 2 from any mode, so it nests inside an interrupt.
- R6: A return from interrupt on a non-empty stack pops the top entry. It loads the popped address into `pc_o` and restores the mode saved in that entry.
- R7: When `flag_we_i` is 1, `c_i`/`z_i` are written into the bank of the mode that was active before the edge, and the other two banks keep their values. `c_o`/`z_o` show the bank of the current mode.
- R8: A push when `depth_o` equals DEPTH does three things: it overwrites the oldest entry, leaves `depth_o` at DEPTH, and sets `ovf_o`. `ovf_o` stays set until reset.
- R9: A return or return from interrupt on an empty stack sets `unf_o`, which stays set until reset. It leaves `pc_o`, the mode and `depth_o` unchanged, and `redir_o` stays 0.
- R10: When several strobes are high together, only one of them acts. The priority order is non-maskable entry, then interrupt entry (if not masked), then return from interrupt, then return, then call.
- R11: `depth_o` counts the valid entries, from 0 to DEPTH. `empty_o` is 1 exactly when the count is 0, and `full_o` is 1 exactly when it is DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Subroutine call strobe |
| ret_i | input | 1 | Subroutine return strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_i | input | 1 | Maskable interrupt entry strobe |
| nmi_i | input | 1 | Non-maskable interrupt entry strobe |
| pc_i | input | 12 | Address of the current instruction |
| tgt_i | input | 12 | Call target or interrupt vector |
| flag_we_i | input | 1 | ALU flag write enable |
| c_i | input | 1 | Carry value from ALU |
| z_i | input | 1 | Zero value from ALU |
| pc_o | output | 12 | Next program counter (registered) |
| redir_o | output | 1 | One-cycle pulse: `pc_o` was just loaded |
| mode_o | output | 2 | Active mode: 0 normal, 1 interrupt, 2 non-maskable |
| c_o | output | 1 | Carry of the active bank |
| z_o | output | 1 | Zero of the active bank |
| depth_o | output | 3 | Number of valid entries |
| empty_o | output | 1 | Stack is empty |
| full_o | output | 1 | Stack holds DEPTH entries |
| ovf_o | output | 1 | Sticky overflow |
| unf_o | output | 1 | Sticky underflow |

## Verification
Every result of a strobe or a flag write becomes visible one rising edge later, since all state and outputs are registers updated on that edge: `pc_o`, `redir_o`, the mode, the flag outputs, the depth and the sticky bits. The bench drives a stimulus before an edge and samples 2 ns after it. At that point it compares every output against a queue-based model that was advanced with the same stimulus. The directed phases cover nesting, masking, wrap on overflow and empty pops, and a long random phase follows them.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_IRQ  = 2'd1,
    MODE_NMI  = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_CALL,
    EV_RET,
    EV_RETI,
    EV_IRQ,
    EV_NMI
  } ev_e;
endpackage

// File: rtl/bcs_lifo.sv
module bcs_lifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 14
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         ovf,
  output logic                         unf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH-1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  top_idx;
  logic [PTR_W-1:0]  nxt_ptr;

  // circular buffer: wr_ptr is the next free slot, top is one below
  assign top_idx = (wr_ptr == '0) ? LAST_IDX : wr_ptr - 1'b1;
  assign nxt_ptr = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
  assign rdata   = mem[top_idx];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else if (push) begin
      wr_ptr <= nxt_ptr;
      if (count == FULL_CNT) ovf   <= 1'b1;
      else                   count <= count + 1'b1;
    end else if (pop) begin
      if (count == '0) begin
        unf <= 1'b1;
      end else begin
        wr_ptr <= top_idx;
        count  <= count - 1'b1;
      end
    end
  end

  a_r11_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
  a_r10_push_pop_excl: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));
  a_r8_overflow_full: assert property (@(posedge clk) disable iff (rst)
    (push && count == FULL_CNT) |=> (ovf && count == FULL_CNT));
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  a_r9_underflow_empty: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && count == '0) |=> (unf && count == '0));
  a_r9_unf_sticky: assert property (@(posedge clk) disable iff (rst)
    unf |=> unf);
endmodule

// File: rtl/bcs_flags.sv
module bcs_flags
  import bcs_pkg::*;
#(
  parameter int BANKS = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode,
  input  logic  we,
  input  logic  c_in,
  input  logic  z_in,
  output logic  c_out,
  output logic  z_out
);
  logic [BANKS-1:0] c_bank;
  logic [BANKS-1:0] z_bank;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        c_bank[b] <= 1'b0;
        z_bank[b] <= 1'b0;
      end else if (we && mode == mode_e'(b)) begin
        c_bank[b] <= c_in;
        z_bank[b] <= z_in;
      end
    end

    a_r7_other_bank_kept: assert property (@(posedge clk) disable iff (rst)
      (!we || mode != mode_e'(b)) |=> ($stable(c_bank[b]) && $stable(z_bank[b])));
  end

  assign c_out = c_bank[mode];
  assign z_out = z_bank[mode];
endmodule

// File: rtl/banked_call_stack.sv
module banked_call_stack
  import bcs_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       call_i,
  input  logic                       ret_i,
  input  logic                       reti_i,
  input  logic                       irq_i,
  input  logic                       nmi_i,
  input  logic [PC_W-1:0]            pc_i,
  input  logic [PC_W-1:0]            tgt_i,
  input  logic                       flag_we_i,
  input  logic                       c_i,
  input  logic                       z_i,
  output logic [PC_W-1:0]            pc_o,
  output logic                       redir_o,
  output logic [1:0]                 mode_o,
  output logic                       c_o,
  output logic                       z_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic                       ovf_o,
  output logic                       unf_o
);
  localparam int ENT_W = PC_W + 2;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PC_W-1:0] CALL_LEN = PC_W'(2);

  mode_e             mode_q;
  ev_e               ev;
  logic              irq_ok;
  logic              push;
  logic              pop;
  logic [PC_W-1:0]   ret_addr;
  logic [ENT_W-1:0]  top_ent;
  logic [CNT_W-1:0]  cnt;
  logic [PC_W-1:0]   pc_q;
  logic              redir_q;

  // maskable entry is blocked while servicing the non-maskable one
  assign irq_ok = irq_i && (mode_q != MODE_NMI);

  always_comb begin
    if (nmi_i)       ev = EV_NMI;
    else if (irq_ok) ev = EV_IRQ;
    else if (reti_i) ev = EV_RETI;
    else if (ret_i)  ev = EV_RET;
    else if (call_i) ev = EV_CALL;
    else             ev = EV_NONE;
  end

  assign push     = (ev == EV_CALL) || (ev == EV_IRQ) || (ev == EV_NMI);
  assign pop      = (ev == EV_RET)  || (ev == EV_RETI);
  assign ret_addr = (ev == EV_CALL) ? pc_i + CALL_LEN : pc_i;

  bcs_lifo #(.DEPTH(DEPTH), .DATA_W(ENT_W)) u_lifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (pop),
    .wdata ({mode_q, ret_addr}),
    .rdata (top_ent),
    .count (cnt),
    .ovf   (ovf_o),
    .unf   (unf_o)
  );

  bcs_flags #(.BANKS(3)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode_q),
    .we    (flag_we_i),
    .c_in  (c_i),
    .z_in  (z_i),
    .c_out (c_o),
    .z_out (z_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      redir_q <= 1'b0;
      mode_q  <= MODE_NORM;
    end else begin
      redir_q <= 1'b0;
      unique case (ev)
        EV_CALL: begin
          pc_q    <= tgt_i;
          redir_q <= 1'b1;
        end
        EV_IRQ: begin
          pc_q    <= tgt_i;
          redir_q <= 1'b1;
          mode_q  <= MODE_IRQ;
        end
        EV_NMI: begin
          pc_q    <= tgt_i;
          redir_q <= 1'b1;
          mode_q  <= MODE_NMI;
        end
        EV_RET: begin
          if (cnt != '0) begin
            pc_q    <= top_ent[PC_W-1:0];
            redir_q <= 1'b1;
          end
        end
        EV_RETI: begin
          if (cnt != '0) begin
            pc_q    <= top_ent[PC_W-1:0];
            redir_q <= 1'b1;
            mode_q  <= mode_e'(top_ent[ENT_W-1 -: 2]);
          end
        end
        default: ;
      endcase
    end
  end

  assign pc_o    = pc_q;
  assign redir_o = redir_q;
  assign mode_o  = mode_q;
  assign depth_o = cnt;
  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CNT_W'(DEPTH));

  a_r2_call_loads_target: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_CALL) |=> (redir_o && pc_o == $past(tgt_i) && $stable(mode_q)));
  a_r3_ret_keeps_mode: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_RET) |=> $stable(mode_q));
  a_r4_irq_masked_in_nmi: assert property (@(posedge clk) disable iff (rst)
    (irq_i && !nmi_i && !reti_i && !ret_i && !call_i && mode_q == MODE_NMI)
      |=> (!redir_o && $stable(cnt) && mode_q == MODE_NMI));
  a_r5_nmi_enters: assert property (@(posedge clk) disable iff (rst)
    nmi_i |=> (mode_q == MODE_NMI && redir_o));
  a_r9_empty_pop_quiet: assert property (@(posedge clk) disable iff (rst)
    (pop && cnt == '0) |=> (!redir_o && $stable(mode_q) && $stable(pc_q)));
  a_r11_mode_legal: assert property (@(posedge clk) disable iff (rst)
    mode_q != 2'd3);
endmodule

// File: tb/banked_call_stack_test.sv
module banked_call_stack_test;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        call_i = 0, ret_i = 0, reti_i = 0, irq_i = 0, nmi_i = 0;
  logic [11:0] pc_i = '0, tgt_i = '0;
  logic        flag_we_i = 0, c_i = 0, z_i = 0;
  logic [11:0] pc_o;
  logic        redir_o, c_o, z_o, empty_o, full_o, ovf_o, unf_o;
  logic [1:0]  mode_o;
  logic [2:0]  depth_o;

  int vectors = 0;
  int fails   = 0;
  string tag  = "R1";

  // reference model state
  int  m_pc[$];
  int  m_md[$];
  int  m_mode, m_pcv, m_redir, m_ovf, m_unf;
  bit  m_c[3], m_z[3];

  always #5 clk = ~clk;

  banked_call_stack #(.PC_W(12), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i), .reti_i(reti_i),
    .irq_i(irq_i), .nmi_i(nmi_i), .pc_i(pc_i), .tgt_i(tgt_i),
    .flag_we_i(flag_we_i), .c_i(c_i), .z_i(z_i), .pc_o(pc_o),
    .redir_o(redir_o), .mode_o(mode_o), .c_o(c_o), .z_o(z_o),
    .depth_o(depth_o), .empty_o(empty_o), .full_o(full_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s/%s %s: actual %0d expected %0d at %0t", tag, req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_pc.delete(); m_md.delete();
    m_mode = 0; m_pcv = 0; m_redir = 0; m_ovf = 0; m_unf = 0;
    for (int b = 0; b < 3; b++) begin m_c[b] = 0; m_z[b] = 0; end
  endtask

  task automatic m_push(int a);
    if (m_pc.size() == DEPTH) begin
      void'(m_pc.pop_front()); void'(m_md.pop_front()); m_ovf = 1;
    end
    m_pc.push_back(a); m_md.push_back(m_mode);
  endtask

  task automatic model_step(bit ca, bit re, bit ri, bit iq, bit nm,
                            int tg, int pv, bit we, bit cc, bit zz);
    if (we) begin m_c[m_mode] = cc; m_z[m_mode] = zz; end
    m_redir = 0;
    if (nm) begin
      m_push(pv); m_pcv = tg; m_mode = 2; m_redir = 1;
    end else if (iq && m_mode != 2) begin
      m_push(pv); m_pcv = tg; m_mode = 1; m_redir = 1;
    end else if (ri || re) begin
      if (m_pc.size() == 0) m_unf = 1;
      else begin
        m_pcv = m_pc.pop_back();
        if (ri) m_mode = m_md.pop_back(); else void'(m_md.pop_back());
        m_redir = 1;
      end
    end else if (ca) begin
      m_push((pv + 2) & 12'hFFF); m_pcv = tg; m_redir = 1;
    end
  endtask

  task automatic compare();
    chk("R2R3R6", "pc_o", pc_o, m_pcv);
    chk("R2R3", "redir_o", redir_o, m_redir);
    chk("R4R5R6", "mode_o", mode_o, m_mode);
    chk("R7", "c_o", c_o, m_c[m_mode]);
    chk("R7", "z_o", z_o, m_z[m_mode]);
    chk("R11", "depth_o", depth_o, m_pc.size());
    chk("R11", "empty_o", empty_o, m_pc.size() == 0);
    chk("R11", "full_o", full_o, m_pc.size() == DEPTH);
    chk("R8", "ovf_o", ovf_o, m_ovf);
    chk("R9", "unf_o", unf_o, m_unf);
  endtask

  task automatic step(bit ca, bit re, bit ri, bit iq, bit nm,
                      int tg, int pv, bit we, bit cc, bit zz);
    call_i = ca; ret_i = re; reti_i = ri; irq_i = iq; nmi_i = nm;
    tgt_i = 12'(tg); pc_i = 12'(pv); flag_we_i = we; c_i = cc; z_i = zz;
    @(posedge clk); #2;
    model_step(ca, re, ri, iq, nm, tg, pv, we, cc, zz);
    compare();
    call_i = 0; ret_i = 0; reti_i = 0; irq_i = 0; nmi_i = 0; flag_we_i = 0;
  endtask

  task automatic idle(); step(0,0,0,0,0, 0,0, 0,0,0); endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(posedge clk);
    #2; rst = 0; model_reset();
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    tag = "R1"; do_reset();
    // R2, R3: nested calls and returns, with a call at the top address
    tag = "R2";
    step(1,0,0,0,0, 12'h100, 12'h010, 0,0,0);
    step(1,0,0,0,0, 12'h200, 12'h105, 0,0,0);
    step(1,0,0,0,0, 12'h300, 12'hFFF, 0,0,0);  // return address wraps to 1
    tag = "R3";
    step(0,1,0,0,0, 0,0, 0,0,0);
    step(0,1,0,0,0, 0,0, 0,0,0);
    step(0,1,0,0,0, 0,0, 0,0,0);
    idle();
    // R7: flags in normal bank
    tag = "R7";
    step(0,0,0,0,0, 0,0, 1,1,0);
    // R4, R5, R6, R7: interrupt, nested NMI, flag writes in each bank
    tag = "R4";
    step(0,0,0,1,0, 12'h040, 12'h222, 0,0,0);
    step(0,0,0,0,0, 0,0, 1,0,1);
    tag = "R5";
    step(0,0,0,0,1, 12'h080, 12'h045, 0,0,0);
    step(0,0,0,0,0, 0,0, 1,1,1);
    tag = "R4";
    step(0,0,0,1,0, 12'h040, 12'h081, 0,0,0);  // masked in NMI mode
    tag = "R6";
    step(0,0,1,0,0, 0,0, 0,0,0);
    step(0,0,1,0,0, 0,0, 0,0,0);
    // R8: overflow wraps over the oldest entry
    tag = "R8";
    for (int i = 0; i < DEPTH + 2; i++)
      step(1,0,0,0,0, 12'h400 + i, 12'h500 + 4*i, 0,0,0);
    for (int i = 0; i < DEPTH; i++) step(0,1,0,0,0, 0,0, 0,0,0);
    // R9: pop on empty
    tag = "R9";
    step(0,1,0,0,0, 0,0, 0,0,0);
    step(0,0,1,0,0, 0,0, 0,0,0);
    // R10: simultaneous strobes
    tag = "R10";
    do_reset();
    step(1,1,1,1,1, 12'h0AA, 12'h011, 0,0,0);
    step(1,1,1,1,0, 12'h0BB, 12'h022, 0,0,0);  // irq masked, reti acts
    step(1,1,0,0,0, 12'h0CC, 12'h033, 0,0,0);  // ret beats call
    step(1,0,0,1,0, 12'h0DD, 12'h044, 0,0,0);
    // random phase
    tag = "RAND";
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 30, (r >= 30 && r < 50), (r >= 50 && r < 60) || r == 99,
           (r >= 60 && r < 68) || r == 98, (r >= 68 && r < 72) || r == 98,
           $urandom_range(0, 4095), $urandom_range(0, 4095),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      if (i == 1500) do_reset();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule